// File: doc/BRIEF.md
# Multi-Channel Timer Compare Bank

This block watches a free-running 64-bit time counter and compares it against a bank of sixteen programmable compare channels. Each channel holds its own 64-bit compare value and its own enable bit. When the counter equals the value of an enabled channel, the block emits a one-clock match pulse for that channel and latches a sticky status flag. The flags are cleared by writing ones to them. A single level-high interrupt stays asserted while any enabled channel has its flag set. The match pulses are meant to start downstream pulse generators.

Channel 0 has a second role. When the cycle-reset option is on, its match also drives a counter-reset pulse, so the counter that feeds this block restarts at zero on the next clock. Loading channel 0 with the cycle length minus the counter increment then gives a cyclic timebase with exactly that period. A shadow option holds new compare values aside and applies them all together at the next channel-0 reset. A cycle that is under way is therefore never cut short or stretched by a half-finished update.

All configuration arrives over a simple write-only register port with word addresses. The counter value is an input, and the block does not own the counter.

Top module: `tmr_cmp_bank`

## Requirements
- R1: After reset all status flags, the interrupt, every match pulse and the counter-reset pulse are 0, and every channel is disabled, so a counter equal to the reset compare value of 0 produces no match.
- R2: When the counter equals the full 64-bit compare value of an enabled channel n, match_o[n] is 1 in that same cycle and status_o[n] is set at the next clock edge. match_o[n] lasts one clock, even if the counter keeps the same value.
- R3: A disabled channel never asserts its match pulse and never sets its status flag.
- R4: Word address 0 is the configuration register. Its bit 0 enables the counter reset on a channel-0 match, bits 16:1 enable channels 0 to 15 (channel n at bit n+1), and bit 17 enables shadow mode. Word address 1 is the status-clear register. Channel n's compare value sits at word address 2+2n (low 32 bits) and 3+2n (high 32 bits). A match needs both words to be equal.
- R5: Status flags are sticky. Writing to address 1 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. When a new match and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: irq_o is 1 exactly while at least one channel that is currently enabled has its status flag set. Disabling a channel removes its flag from the interrupt but does not clear the flag.
- R7: With configuration bit 0 set, cnt_rst_o is asserted in the same cycle as match_o[0]. With channel 0 loaded with P minus the increment, and the counter cleared on cnt_rst_o, resets occur every P/increment clocks. With bit 0 clear, cnt_rst_o stays 0.
- R8: In shadow mode, compare writes leave the active compare values unchanged. All pending values become active at the clock edge that ends a cycle in which cnt_rst_o is 1.
- R9: Outside shadow mode, a compare word write becomes active at the clock edge that samples it, so a counter equal to the new value gives a match in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 64 | Current time counter value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register word address |
| wr_data | input | 32 | Register write data |
| match_o | output | 16 | One-clock match pulse per channel |
| status_o | output | 16 | Sticky match flags |
| irq_o | output | 1 | Level interrupt: any enabled channel flagged |
| cnt_rst_o | output | 1 | Counter-reset request from channel 0 |

## Verification
Faults in this block show up quickly at the ports. A wrong compare word or a wrong enable shows up as a missing or extra match pulse in the very cycle the counter reaches the value, and as a wrong status bit one edge later. A wrong shadow or active copy only shows in the cycle length: the first reset after a shadowed write must still land on the old value, and the cycle after it must have the new length. A wrong edge detector or status register shows as a pulse that repeats while the counter holds its value, or as a flag that is lost or wrongly kept after a clear.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
   localparam int ADR_CFG     = 0;
   localparam int ADR_STAT    = 1;
   localparam int ADR_CH_BASE = 2;

   function automatic int word_addr(input int ch, input int w, input int words);
      return ADR_CH_BASE + ch * words + w;
   endfunction
endpackage

// File: rtl/cmp_cfg_regs.sv
module cmp_cfg_regs
   import tmr_cmp_pkg::*;
#(
   parameter int NUM_CH      = 16,
   parameter int BUS_W       = 32,
   parameter int WORDS       = 2,
   parameter int ADDR_W      = 6,
   parameter bit SHADOW_IMPL = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [BUS_W-1:0]          wr_data,
   output logic                      rst_en_o,
   output logic [NUM_CH-1:0]         ch_en_o,
   output logic                      shadow_en_o,
   output logic [NUM_CH-1:0]         stat_clr_o,
   output logic [NUM_CH*WORDS-1:0]   word_we_o
);
   localparam int CFG_W = NUM_CH + 2;

   logic cfg_hit;
   logic stat_hit;
   logic rst_en_q;
   logic [NUM_CH-1:0] ch_en_q;

   assign cfg_hit  = wr_en && (wr_addr == ADDR_W'(ADR_CFG));
   assign stat_hit = wr_en && (wr_addr == ADDR_W'(ADR_STAT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_en_q <= 1'b0;
         ch_en_q  <= '0;
      end else if (cfg_hit) begin
         rst_en_q <= wr_data[0];
         ch_en_q  <= wr_data[NUM_CH:1];
      end
   end

   generate
      if (SHADOW_IMPL) begin : g_shadow_bit
         logic shadow_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       shadow_q <= 1'b0;
            else if (cfg_hit) shadow_q <= wr_data[NUM_CH+1];
         end
         assign shadow_en_o = shadow_q;
      end else begin : g_no_shadow_bit
         logic unused_shadow_bit;
         assign unused_shadow_bit = wr_data[NUM_CH+1];
         assign shadow_en_o = 1'b0;
      end

      if (BUS_W > CFG_W) begin : g_upper_sink
         logic unused_upper;
         assign unused_upper = ^wr_data[BUS_W-1:CFG_W];
      end

      for (genvar i = 0; i < NUM_CH * WORDS; i++) begin : g_word_we
         assign word_we_o[i] = wr_en && (wr_addr == ADDR_W'(ADR_CH_BASE + i));
      end
   endgenerate

   assign rst_en_o   = rst_en_q;
   assign ch_en_o    = ch_en_q;
   assign stat_clr_o = stat_hit ? wr_data[NUM_CH-1:0] : '0;
endmodule

// File: rtl/cmp_chan.sv
module cmp_chan #(
   parameter int CNT_W       = 64,
   parameter int BUS_W       = 32,
   parameter int WORDS       = 2,
   parameter bit SHADOW_IMPL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORDS-1:0]  word_we,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              shadow_en,
   input  logic              load_act,
   input  logic              enable,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              hit_o
);
   logic [WORDS-1:0][BUS_W-1:0] act_q;

   generate
      if (SHADOW_IMPL) begin : g_shadowed
         logic [WORDS-1:0][BUS_W-1:0] shd_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               shd_q <= '0;
            end else begin
               for (int w = 0; w < WORDS; w++) begin
                  if (word_we[w]) shd_q[w] <= wr_data;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               act_q <= '0;
            end else begin
               if (load_act) act_q <= shd_q;
               for (int w = 0; w < WORDS; w++) begin
                  if (word_we[w] && !shadow_en) act_q[w] <= wr_data;
               end
            end
         end
      end else begin : g_direct
         logic unused_shadow_ctl;
         assign unused_shadow_ctl = shadow_en ^ load_act;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               act_q <= '0;
            end else begin
               for (int w = 0; w < WORDS; w++) begin
                  if (word_we[w]) act_q[w] <= wr_data;
               end
            end
         end
      end
   endgenerate

   assign hit_o = enable && (act_q == cnt_i);
endmodule

// File: rtl/cmp_stat.sv
module cmp_stat #(
   parameter int NUM_CH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] hit_i,
   input  logic [NUM_CH-1:0] clr_i,
   input  logic [NUM_CH-1:0] en_i,
   output logic [NUM_CH-1:0] match_o,
   output logic [NUM_CH-1:0] status_o,
   output logic              irq_o
);
   logic [NUM_CH-1:0] hit_q;
   logic [NUM_CH-1:0] st_q;

   assign match_o = hit_i & ~hit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q <= '0;
         st_q  <= '0;
      end else begin
         hit_q <= hit_i;
         st_q  <= (st_q & ~clr_i) | match_o;
      end
   end

   assign status_o = st_q;
   assign irq_o    = |(st_q & en_i);
endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
   parameter int NUM_CH      = 16,
   parameter int CNT_W       = 64,
   parameter int BUS_W       = 32,
   parameter bit SHADOW_IMPL = 1'b1,
   localparam int WORDS      = CNT_W / BUS_W,
   localparam int NUM_REGS   = 2 + NUM_CH * WORDS,
   localparam int ADDR_W     = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   output logic [NUM_CH-1:0] match_o,
   output logic [NUM_CH-1:0] status_o,
   output logic              irq_o,
   output logic              cnt_rst_o
);
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (NUM_CH + 2 > BUS_W) begin : g_bad_cfg
         $error("configuration register does not fit the bus width");
      end
      if (CNT_W % BUS_W != 0) begin : g_bad_words
         $error("CNT_W must be a multiple of BUS_W");
      end
   endgenerate

   logic                    rst_en;
   logic [NUM_CH-1:0]       ch_en;
   logic                    shadow_en;
   logic [NUM_CH-1:0]       stat_clr;
   logic [NUM_CH*WORDS-1:0] word_we;
   logic [NUM_CH-1:0]       hit;
   logic                    load_act;

   cmp_cfg_regs #(
      .NUM_CH(NUM_CH), .BUS_W(BUS_W), .WORDS(WORDS),
      .ADDR_W(ADDR_W), .SHADOW_IMPL(SHADOW_IMPL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rst_en_o(rst_en), .ch_en_o(ch_en), .shadow_en_o(shadow_en),
      .stat_clr_o(stat_clr), .word_we_o(word_we)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         cmp_chan #(
            .CNT_W(CNT_W), .BUS_W(BUS_W), .WORDS(WORDS), .SHADOW_IMPL(SHADOW_IMPL)
         ) u_ch (
            .clk(clk), .rst_n(rst_n),
            .word_we(word_we[c*WORDS +: WORDS]),
            .wr_data(wr_data),
            .shadow_en(shadow_en),
            .load_act(load_act),
            .enable(ch_en[c]),
            .cnt_i(cnt_i),
            .hit_o(hit[c])
         );
      end
   endgenerate

   cmp_stat #(.NUM_CH(NUM_CH)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .hit_i(hit), .clr_i(stat_clr), .en_i(ch_en),
      .match_o(match_o), .status_o(status_o), .irq_o(irq_o)
   );

   assign cnt_rst_o = rst_en && match_o[0];
   assign load_act  = cnt_rst_o && shadow_en;
endmodule

// File: rtl/tmr_cmp_bank_chk.sv
module tmr_cmp_bank_chk
   import tmr_cmp_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [BUS_W-1:0]  wr_data,
   input logic [NUM_CH-1:0] match_o,
   input logic [NUM_CH-1:0] status_o,
   input logic              irq_o,
   input logic              cnt_rst_o,
   input logic [NUM_CH-1:0] ch_en
);
   logic [NUM_CH-1:0] clr_v;
   logic [NUM_CH-1:0] keep_v;
   logic unused_hi;

   assign clr_v  = (wr_en && wr_addr == ADDR_W'(ADR_STAT)) ? wr_data[NUM_CH-1:0] : '0;
   assign keep_v = status_o & ~clr_v;
   assign unused_hi = ^wr_data;

   // R3
   dis_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o & ~ch_en) == '0);

   // R7
   rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst_o |-> match_o[0]);

   // R2
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o != '0) |=> ((match_o & $past(match_o)) == '0));

   // R2
   match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_o & $past(match_o)) == $past(match_o)));

   // R5
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_o & $past(keep_v)) == $past(keep_v)));

   // R5
   rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_o & ~$past(status_o) & ~$past(match_o)) == '0));

   // R6
   irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == '0) |-> !irq_o);
endmodule

bind tmr_cmp_bank tmr_cmp_bank_chk #(
   .NUM_CH(NUM_CH), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .match_o(match_o), .status_o(status_o), .irq_o(irq_o), .cnt_rst_o(cnt_rst_o),
   .ch_en(ch_en)
);

// File: tb/sim_tmr_cmp_bank.sv
module sim_tmr_cmp_bank;
   localparam int AW  = 6;
   localparam int INC = 4;
   localparam logic [15:0] EN = 16'hA5C3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cnt = '0;
   logic        wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [15:0] match_o;
   logic [15:0] status_o;
   logic        irq_o;
   logic        cnt_rst_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   bit run = 0;
   logic [63:0] hold_val = '0;
   logic        last_rst = 1'b0;
   logic [15:0] last_match = '0;
   logic [15:0] exp_st;

   always #4 clk = ~clk;

   tmr_cmp_bank u0 (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .match_o(match_o), .status_o(status_o), .irq_o(irq_o), .cnt_rst_o(cnt_rst_o)
   );

   function automatic logic [63:0] vch(input int n);
      return {32'(5 + n), 32'(32'h1000 + 16 * n)};
   endfunction

   function automatic logic [31:0] cfgw(input bit rst, input logic [15:0] en, input bit sh);
      return {14'd0, sh, en, rst};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic we = 1'b0, input logic [AW-1:0] a = '0, input logic [31:0] d = '0);
      @(negedge clk);
      if (run) cnt = last_rst ? 64'd0 : cnt + 64'(INC);
      else     cnt = hold_val;
      wr_en = we; wr_addr = a; wr_data = d;
      #1;
      last_rst   = cnt_rst_o;
      last_match = match_o;
   endtask

   task automatic meas(output logic [63:0] at, output int per);
      int k;
      k = 0;
      do begin cyc(); k++; end while (!last_rst && k < 400);
      at = cnt;
      per = 0;
      do begin cyc(); per++; end while (!last_rst && per < 400);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] at;
      int per;
      int cnt_r;
      repeat (3) @(posedge clk);
      hold_val = 64'd0;
      cyc();
      // R1: reset state, counter at reset compare value 0
      chk("R1 status", status_o, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 match", match_o, 0);
      chk("R1 cnt_rst", cnt_rst_o, 0);
      rst_n = 1'b1;
      cyc();
      chk("R1 no match after reset", match_o, 0);

      // R4: program all channels, enable pattern EN
      hold_val = 64'hFFFF_FFFF_FFFF_FFFF;
      for (int n = 0; n < 16; n++) begin
         cyc(1'b1, AW'(2 + 2 * n), vch(n)[31:0]);
         cyc(1'b1, AW'(3 + 2 * n), vch(n)[63:32]);
      end
      cyc(1'b1, AW'(0), cfgw(1'b0, EN, 1'b0));
      cyc();
      exp_st = '0;
      // R2 / R3 sweep over every channel
      for (int n = 0; n < 16; n++) begin
         hold_val = vch(n);
         cyc();
         chk($sformatf("R2 R3 match ch%0d", n), match_o, EN[n] ? 16'(1 << n) : 16'd0);
         chk("R7 no reset when disabled", cnt_rst_o, 0);
         cyc();
         chk($sformatf("R2 single pulse ch%0d", n), match_o, 0);
         if (EN[n]) exp_st[n] = 1'b1;
         chk($sformatf("R2 R3 status ch%0d", n), status_o, exp_st);
         chk("R6 irq", irq_o, |(exp_st & EN));
      end

      // R4: high word differs, low word matches channel 3
      hold_val = {32'h9, vch(3)[31:0]};
      cyc();
      chk("R4 high word mismatch", match_o, 0);
      cyc();

      // R5: write-zero no effect, partial clear, set beats clear
      cyc(1'b1, AW'(1), 32'h0);
      cyc();
      chk("R5 write zero", status_o, exp_st);
      cyc(1'b1, AW'(1), 32'h3);
      cyc();
      exp_st = exp_st & ~16'h3;
      chk("R5 partial clear", status_o, exp_st);
      hold_val = vch(0);
      cyc(1'b1, AW'(1), 32'h1);
      cyc();
      exp_st[0] = 1'b1;
      chk("R5 set beats clear", status_o, exp_st);

      // R6: disable a flagged channel
      hold_val = {32'h9, 32'h0};
      cyc(1'b1, AW'(1), 32'hFFFF);
      cyc();
      chk("R5 clear all", status_o, 0);
      chk("R6 irq low", irq_o, 0);
      hold_val = vch(7);
      cyc();
      cyc();
      chk("R6 irq high", irq_o, 1);
      cyc(1'b1, AW'(0), cfgw(1'b0, EN & ~16'h0080, 1'b0));
      cyc();
      chk("R6 irq masked", irq_o, 0);
      chk("R6 flag kept", status_o, 16'h0080);

      // R9: direct update takes effect at the sampling edge
      hold_val = 64'h0000_0077_0000_0099;
      cyc(1'b1, AW'(0), cfgw(1'b0, 16'h0004, 1'b0));
      cyc(1'b1, AW'(7), 32'h77);
      chk("R9 before low write", match_o, 0);
      cyc(1'b1, AW'(6), 32'h99);
      chk("R9 same cycle", match_o, 0);
      cyc();
      chk("R9 after write", match_o, 16'h0004);

      // R7: cyclic timebase, P = 40, INC = 4
      hold_val = 64'hFFFF_FFFF_FFFF_FFFF;
      cyc(1'b1, AW'(2), 32'd36);
      cyc(1'b1, AW'(3), 32'd0);
      cyc(1'b1, AW'(0), cfgw(1'b1, 16'h0001, 1'b0));
      hold_val = 64'd0;
      cyc();
      run = 1;
      meas(at, per);
      chk("R7 reset point", at, 36);
      chk("R7 period", per, 10);
      chk("R7 reset with match", last_match[0], 1);
      meas(at, per);
      chk("R7 period again", per, 10);
      cyc(1'b1, AW'(0), cfgw(1'b0, 16'h0001, 1'b0));
      cnt_r = 0;
      for (int k = 0; k < 40; k++) begin
         cyc();
         if (last_rst) cnt_r++;
      end
      chk("R7 reset disabled", cnt_r, 0);

      // R8: shadow mode defers the new cycle length
      run = 0;
      hold_val = 64'hFFFF_FFFF_FFFF_FFFF;
      cyc(1'b1, AW'(0), cfgw(1'b1, 16'h0001, 1'b1));
      hold_val = 64'd0;
      cyc();
      run = 1;
      meas(at, per);
      chk("R8 period before write", per, 10);
      cyc(1'b1, AW'(2), 32'd76);
      meas(at, per);
      chk("R8 old value kept", at, 36);
      chk("R8 new period", per, 20);
      meas(at, per);
      chk("R8 new reset point", at, 76);
      run = 0;

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule